// File: doc/BRIEF.md
# RTC seconds counter with alarm

This block is a real-time clock peripheral that keeps a 32-bit count of seconds and compares it against a 32-bit alarm value. A slow-clock enable pulse (`slow_tick`) arrives on the system clock. A prescaler divides it down to one step per second. Software sees a small register file through a simple single-cycle bus: writes are strobed and reads are combinational. The registers are control, seconds, alarm seconds, a general-purpose regulator word, a scratchpad and a write-unlock word. The scratchpad lets software mark the time as valid after setting it.

Every register write is guarded twice. The unlock word must first receive the key value, and the write-ready bit must be set. An accepted write consumes the unlock and starts a busy window that lasts a fixed number of slow-clock pulses. The two event flags (one per second, and alarm match) are set by hardware. Software clears a flag by writing 0 to its bit, and writing 1 leaves it alone, so a read-modify-write cannot lose an event. The interrupt output combines each flag with its own enable.

Top module: `rtc_sec_alarm`

## Requirements
- R1: After reset every register reads 0, except that control reads 0x80 (write-ready set), and `irq` is 0.
- R2: Writing exactly 0x0000A55A to offset 0x3C sets bit 31 of that register (unlocked). Writing any other value there clears it. While bit 31 is clear, writes to offsets 0x00, 0x04, 0x08, 0x0C and 0x34 change nothing.
- R3: A write to offset 0x00, 0x04, 0x08, 0x0C or 0x34 is accepted only when unlocked and write-ready (control bit 7). An accepted write clears the unlock bit and clears write-ready for exactly WR_BUSY slow-clock pulses. A write attempted while write-ready is clear is ignored and leaves the unlock bit set.
- R4: While control bit 0 (enable) is set, the seconds register at 0x04 increments once every TICKS_PER_SEC slow-clock pulses and wraps from 0xFFFFFFFF to 0. While enable is clear it holds. The prescaler keeps its phase across a write to seconds.
- R5: Control bit 6 (per-second flag) is set on every seconds step. An accepted control write with bit 6 at 0 clears the flag, and one with bit 6 at 1 leaves it unchanged.
- R6: Control bit 4 (alarm flag) is set when the seconds count steps to a value equal to the alarm register at 0x08 while control bit 2 (alarm enable) is set. It is never set while bit 2 is clear. It is cleared by writing 0 to bit 4, and writing 1 leaves it unchanged.
- R7: `irq` is high exactly when (bit 6 and bit 5) or (bit 4 and bit 3) of control are set.
- R8: Offsets 0x08, 0x0C and 0x34 read back the last accepted 32-bit value. Control bits 0, 2, 3 and 5 read back as written, bit 7 cannot be written, and bits 1 and 31:8 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_tick | input | 1 | One-cycle pulse per slow-clock period |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `slow_tick` is a single-cycle pulse on the system clock. They also assume that bus writes are one-cycle strobes with the address and data stable in the cycle the strobe is high. The bench drives every input on the falling edge, pulses the tick for exactly one cycle, and never raises a tick and a bus write in the same cycle. Each second and each busy window therefore consists of whole pulses that the bench can count arithmetically.

// File: rtl/rtc_sec_alarm.sv
module rtc_sec_alarm #(
  parameter int          TICKS_PER_SEC = 4,
  parameter int          WR_BUSY       = 4,
  parameter logic [31:0] UNLOCK_KEY    = 32'h0000_A55A
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        slow_tick,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [5:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);
  localparam int PW = $clog2(TICKS_PER_SEC + 1);
  localparam int BW = $clog2(WR_BUSY + 1);
  localparam logic [5:0] A_CTRL = 6'h00, A_SECS = 6'h04, A_ALRM = 6'h08,
                         A_REGU = 6'h0C, A_SCRT = 6'h34, A_UNLK = 6'h3C;

  logic [PW-1:0] presc_q;
  logic [BW-1:0] busy_q;
  logic          unlocked_q;
  logic          en_q, ae_q, aie_q, hie_q, hz_q, al_q;
  logic [31:0]   secs_q, alarm_q, regu_q, scrt_q;

  logic wr_strobe, addr_ok, ready, accept, sec_wr, ctl_wr, sec_step;
  logic [7:0] ctrl_view;

  assign ready     = (busy_q == '0);
  assign wr_strobe = bus_sel & bus_wr;
  assign addr_ok   = (bus_addr == A_CTRL) | (bus_addr == A_SECS) | (bus_addr == A_ALRM) |
                     (bus_addr == A_REGU) | (bus_addr == A_SCRT);
  assign accept    = wr_strobe & addr_ok & unlocked_q & ready;
  assign sec_wr    = accept & (bus_addr == A_SECS);
  assign ctl_wr    = accept & (bus_addr == A_CTRL);
  assign sec_step  = en_q & slow_tick & (presc_q == PW'(TICKS_PER_SEC - 1)) & ~sec_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) presc_q <= '0;
    else if (en_q && slow_tick)
      presc_q <= (presc_q == PW'(TICKS_PER_SEC - 1)) ? '0 : presc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     busy_q <= '0;
    else if (accept)                busy_q <= BW'(WR_BUSY);
    else if (slow_tick && !ready)   busy_q <= busy_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                    unlocked_q <= 1'b0;
    else if (accept)                               unlocked_q <= 1'b0;
    else if (wr_strobe && bus_addr == A_UNLK)      unlocked_q <= (bus_wdata == UNLOCK_KEY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      secs_q <= '0; alarm_q <= '0; regu_q <= '0; scrt_q <= '0;
    end else begin
      if (sec_wr)        secs_q <= bus_wdata;
      else if (sec_step) secs_q <= secs_q + 1'b1;
      if (accept && bus_addr == A_ALRM) alarm_q <= bus_wdata;
      if (accept && bus_addr == A_REGU) regu_q  <= bus_wdata;
      if (accept && bus_addr == A_SCRT) scrt_q  <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; ae_q <= 1'b0; aie_q <= 1'b0; hie_q <= 1'b0;
    end else if (ctl_wr) begin
      en_q  <= bus_wdata[0];
      ae_q  <= bus_wdata[2];
      aie_q <= bus_wdata[3];
      hie_q <= bus_wdata[5];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hz_q <= 1'b0; al_q <= 1'b0;
    end else begin
      if (sec_step)                   hz_q <= 1'b1;
      else if (ctl_wr && !bus_wdata[6]) hz_q <= 1'b0;
      if (sec_step && ae_q && (secs_q + 1'b1) == alarm_q) al_q <= 1'b1;
      else if (ctl_wr && !bus_wdata[4])                   al_q <= 1'b0;
    end
  end

  assign ctrl_view = {ready, hz_q, hie_q, al_q, aie_q, ae_q, 1'b0, en_q};

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {24'h0, ctrl_view};
      A_SECS:  bus_rdata = secs_q;
      A_ALRM:  bus_rdata = alarm_q;
      A_REGU:  bus_rdata = regu_q;
      A_SCRT:  bus_rdata = scrt_q;
      A_UNLK:  bus_rdata = {unlocked_q, 31'h0};
      default: bus_rdata = '0;
    endcase
  end

  assign irq = (hz_q & hie_q) | (al_q & aie_q);
endmodule

// File: rtl/rtc_sec_alarm_chk.sv
module rtc_sec_alarm_chk #(
  parameter int WR_BUSY = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        slow_tick,
  input logic        bus_sel,
  input logic        bus_wr,
  input logic [5:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic        unlocked,
  input logic        ready,
  input logic        en,
  input logic        hz,
  input logic        al,
  input logic [31:0] secs,
  input logic [31:0] scrt,
  input logic        irq
);
  // R2
  locked_scratch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && !unlocked && bus_addr == 6'h34) |=> $stable(scrt));

  // R3
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !slow_tick) |=> !ready);

  // R3
  relock_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && unlocked && ready && bus_addr == 6'h34) |=> (!unlocked && !ready));

  // R4
  frozen_secs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !(bus_sel && bus_wr && bus_addr == 6'h04)) |=> $stable(secs));

  // R5
  flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hz && !(bus_sel && bus_wr && bus_addr == 6'h00 && !bus_wdata[6])) |=> hz);

  // R7
  quiet_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hz && !al) |-> !irq);
endmodule

bind rtc_sec_alarm rtc_sec_alarm_chk #(.WR_BUSY(WR_BUSY)) u_chk (
  .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .unlocked(unlocked_q), .ready(ready),
  .en(en_q), .hz(hz_q), .al(al_q), .secs(secs_q), .scrt(scrt_q), .irq(irq)
);

// File: tb/test_rtc_sec_alarm.sv
module test_rtc_sec_alarm;
  localparam int TPS = 4;
  localparam int WRB = 4;

  logic clk = 0, rst_n = 0, slow_tick = 0, bus_sel = 0, bus_wr = 0;
  logic [5:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic        irq;

  int checks = 0, fails = 0;
  bit done = 0;
  int exp_presc = 0;
  bit exp_en = 0;
  logic [31:0] exp_secs = 0;

  always #4 clk = ~clk;

  rtc_sec_alarm #(.TICKS_PER_SEC(TPS), .WR_BUSY(WRB)) i_rtc_sec_alarm (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input logic [5:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); bus_addr = a; #1;
    chk(bus_rdata === exp, req, bus_rdata, exp);
  endtask

  task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); slow_tick = 1;
      @(negedge clk); slow_tick = 0;
      if (exp_en) begin
        exp_presc++;
        if (exp_presc == TPS) begin exp_presc = 0; exp_secs++; end
      end
    end
  endtask

  task automatic wr_nowait(input logic [5:0] a, input logic [31:0] d);
    bus_write(6'h3C, 32'h0000_A55A);
    bus_write(a, d);
    if (a == 6'h00) exp_en = d[0];
    if (a == 6'h04) exp_secs = d;
  endtask

  task automatic wr_reg(input logic [5:0] a, input logic [31:0] d);
    wr_nowait(a, d);
    tick_n(WRB);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd_chk(6'h00, 32'h80, "R1 ctrl");
    rd_chk(6'h04, 32'h0, "R1 secs");
    rd_chk(6'h3C, 32'h0, "R1 unlock");
    rd_chk(6'h34, 32'h0, "R1 scratch");
    chk(irq === 1'b0, "R1 irq", {31'h0, irq}, 32'h0);

    // R2 locked writes, wrong key, right key
    bus_write(6'h34, 32'h1111_2222);
    rd_chk(6'h34, 32'h0, "R2 locked write ignored");
    bus_write(6'h3C, 32'h0000_1234);
    rd_chk(6'h3C, 32'h0, "R2 wrong key");
    bus_write(6'h3C, 32'h0000_A55A);
    rd_chk(6'h3C, 32'h8000_0000, "R2 key unlocks");

    // R3 accepted write relocks and starts busy window
    bus_write(6'h34, 32'h1234_5678);
    rd_chk(6'h34, 32'h1234_5678, "R3 accepted write");
    rd_chk(6'h3C, 32'h0, "R3 relocked");
    rd_chk(6'h00, 32'h00, "R3 not ready");
    bus_write(6'h3C, 32'h0000_A55A);
    bus_write(6'h34, 32'h0000_DEAD);
    rd_chk(6'h34, 32'h1234_5678, "R3 busy write ignored");
    rd_chk(6'h3C, 32'h8000_0000, "R3 unlock kept");
    tick_n(WRB - 1);
    rd_chk(6'h00, 32'h00, "R3 still busy");
    tick_n(1);
    rd_chk(6'h00, 32'h80, "R3 ready again");
    bus_write(6'h3C, 32'h0);
    rd_chk(6'h3C, 32'h0, "R2 relock by other value");
    bus_write(6'h34, 32'h5555_5555);
    rd_chk(6'h34, 32'h1234_5678, "R2 locked write ignored after relock");

    // R8 control sweep with enable clear
    for (int v = 0; v < 256; v += 2) begin
      wr_nowait(6'h00, 32'(v) | 32'hFFFF_FF00);
      rd_chk(6'h00, 32'(v) & 32'h2C, "R8 ctrl bits");
      tick_n(WRB);
    end
    wr_reg(6'h00, 32'h0);
    // R8 data registers
    for (int i = 0; i < 12; i++) begin
      logic [31:0] p;
      p = 32'h9E37_79B9 * (i + 1);
      wr_reg(6'h0C, p);  rd_chk(6'h0C, p, "R8 regulator");
      wr_reg(6'h08, ~p); rd_chk(6'h08, ~p, "R8 alarm");
      wr_reg(6'h34, p ^ 32'hA5A5_0000); rd_chk(6'h34, p ^ 32'hA5A5_0000, "R8 scratch");
    end

    // R4 frozen then counting
    wr_reg(6'h04, 32'd100);
    tick_n(12);
    rd_chk(6'h04, 32'd100, "R4 frozen");
    wr_reg(6'h00, 32'h1);
    rd_chk(6'h04, exp_secs, "R4 first second");
    rd_chk(6'h00, 32'hC1, "R5 flag set on step");
    tick_n(8);
    rd_chk(6'h04, exp_secs, "R4 counting");
    chk(exp_secs == 32'd103, "R4 model", exp_secs, 32'd103);

    // R5 clear by 0, keep by 1
    wr_nowait(6'h00, 32'h01);
    rd_chk(6'h00, 32'h01, "R5 write 0 clears");
    tick_n(WRB);
    rd_chk(6'h00, 32'hC1, "R5 set again");
    wr_nowait(6'h00, 32'h41);
    rd_chk(6'h00, 32'h41, "R5 write 1 keeps");
    tick_n(WRB);

    // R7 irq
    wr_nowait(6'h00, 32'h61);
    rd_chk(6'h00, 32'h61, "R7 ctrl");
    chk(irq === 1'b1, "R7 irq from per-second flag", {31'h0, irq}, 32'h1);
    tick_n(WRB);
    wr_nowait(6'h00, 32'h21);
    #1 chk(irq === 1'b0, "R7 irq drops with flag", {31'h0, irq}, 32'h0);
    tick_n(WRB);
    #1 chk(irq === 1'b1, "R7 irq on next step", {31'h0, irq}, 32'h1);
    wr_reg(6'h00, 32'h00);

    // R6 alarm match
    wr_reg(6'h08, exp_secs + 2);
    wr_nowait(6'h00, 32'h0D);
    rd_chk(6'h00, 32'h0D, "R6 ctrl");
    tick_n(WRB);
    rd_chk(6'h00, 32'hCD, "R6 no match yet");
    chk(irq === 1'b0, "R7 no irq without match", {31'h0, irq}, 32'h0);
    tick_n(TPS);
    rd_chk(6'h00, 32'hDD, "R6 alarm flag on match");
    chk(irq === 1'b1, "R7 irq from alarm", {31'h0, irq}, 32'h1);
    tick_n(TPS);
    rd_chk(6'h00, 32'hDD, "R6 flag sticky");
    wr_nowait(6'h00, 32'h0D);
    rd_chk(6'h00, 32'h0D, "R6 flags cleared");
    chk(irq === 1'b0, "R7 irq cleared", {31'h0, irq}, 32'h0);
    tick_n(WRB);

    // R6 no match while alarm enable clear
    wr_reg(6'h00, 32'h09);
    wr_reg(6'h08, exp_secs + 1);
    tick_n(3 * TPS);
    rd_chk(6'h00, 32'hC9, "R6 disabled no flag");
    chk(irq === 1'b0, "R6 disabled no irq", {31'h0, irq}, 32'h0);

    // R4 wrap
    wr_reg(6'h04, 32'hFFFF_FFFF);
    rd_chk(6'h04, exp_secs, "R4 wrap");
    chk(exp_secs == 32'h0, "R4 wrap model", exp_secs, 32'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule